// File: doc/BRIEF.md
# I2C Register-File Slave

This block is a fast-mode I2C target that holds six 8-bit control registers and presents their contents as a parallel bus to the surrounding logic. A system clock much faster than SCL oversamples both bus lines. Each line passes through a synchroniser and a glitch filter, and the filtered lines feed an edge and condition detector. A byte engine then moves through the address, register-pointer and data phases.

The block responds to one fixed 7-bit device address. Writes carry a register pointer byte followed by any number of data bytes. Reads either continue from the retained pointer (current-address read) or follow a pointer write and a repeated START (random read). The pointer advances after every data byte and wraps from the last register back to register 0. SDA is driven open-drain: the output data is always low, and the output enable pulls the line.

Bits that are defined as fixed zero can never be set. Pointer values past the last register are accepted, but writes there are dropped and reads there return zero.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset the parallel outputs hold 32h, A1h, 3Eh, 3Eh, FFh, 09h for registers 0 to 5 (register i on bits 8i+7:8i of `regs_o`), and SDA is not driven.
- R2: A first byte whose upper seven bits equal 0010011 is acknowledged, with SDA pulled low during the ninth SCL pulse; bit 0 of that byte selects read (1) or write (0). Any other device address gets no acknowledge, and the following bytes of that transaction are neither acknowledged nor applied.
- R3: In a write, the byte after the device address sets the register pointer from its low 5 bits; its upper 3 bits are ignored.
- R4: Each written data byte goes to the pointed register and the pointer then advances, wrapping from 05h to 00h. Every write byte is acknowledged.
- R5: Fixed-zero bits always read and output as 0: bits 3:2 of register 0, bits 6, 3 and 1 of register 1, and bits 7:4 of register 5.
- R6: A read with no preceding pointer phase returns the register one past the last accessed one, and the pointer is retained across STOP.
- R7: A pointer write followed by a repeated START with the read bit set returns data starting at that pointer.
- R8: During a read, each byte is sent MSB first, and an acknowledge from the master continues with the next register, wrapping from 05h to 00h.
- R9: A missing master acknowledge after a read byte stops transmission; SDA stays released until the next START or STOP.
- R10: Pointer values 06h to 1Fh are acknowledged on write but change no register, and reads from them return 00h.
- R11: A START or STOP at any point, including in the middle of a byte, abandons the partial byte without applying it and resets the byte engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| sda_o | output | 1 | SDA output data, always low (open-drain) |
| sda_oe | output | 1 | SDA output enable; high pulls the line low |
| regs_o | output | 48 | Register contents, register i on bits 8i+7:8i |

## Verification
Burst writes that start mid-map and cross the wrap point separate a pointer that wraps correctly from one that runs on into the unused range. They also show whether the write masks are applied. Current-address reads issued after writes, after reads and after an aborted byte separate a pointer that is retained and advanced from one that is reset per transaction. Random reads with master ACK chains across the wrap, and with a final NACK followed by extra clocks, show whether the transmitter stops when it should. A foreign device address, writes and reads in the 06h to 1Fh range, and START or STOP injected mid-byte confirm that nothing outside a valid, completed byte ever reaches the registers.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int DW   = 8;
  localparam int PW   = 5;
  localparam int NREG = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_REG, S_WR, S_SACK, S_TX, S_MACK, S_HOLD
  } eng_st_t;

  // power-up contents of each register
  function automatic logic [DW-1:0] rst_val(input int idx);
    case (idx)
      0:       return 8'h32;
      1:       return 8'hA1;
      2:       return 8'h3E;
      3:       return 8'h3E;
      4:       return 8'hFF;
      5:       return 8'h09;
      default: return '0;
    endcase
  endfunction

  // writable bits of each register; cleared bits are fixed zero
  function automatic logic [DW-1:0] wr_mask(input int idx);
    case (idx)
      0:       return 8'hF3;
      1:       return 8'hB5;
      5:       return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(NREG-1)) ? '0 : p + 1'b1;
  endfunction
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
  parameter int STAGES   = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_raw,
  output logic line_f
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [STAGES-1:0] sh;
  logic [CW-1:0]     cnt;
  logic              q;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], line_raw};
  end

  // a new level is taken only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b1;
      cnt <= '0;
    end else if (sh[STAGES-1] == q) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT_LEN - 1)) begin
      q   <= sh[STAGES-1];
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign line_f = q;
endmodule

// File: rtl/i2cr_cond.sv
module i2cr_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_e,
  output logic stop_e
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_e  = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_e   = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_e,
  input  logic          stop_e,
  input  logic          sda_f,
  input  logic [DW-1:0] rd_data,
  output logic [PW-1:0] rd_addr,
  output logic          wr_en,
  output logic [PW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sda_oe
);
  localparam int BCW = $clog2(DW + 1);

  eng_st_t        st, after;
  logic [BCW-1:0] bcnt;
  logic [DW-1:0]  sh;
  logic [PW-1:0]  ptr;
  logic           oe;
  logic           mack_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      after   <= S_IDLE;
      bcnt    <= '0;
      sh      <= '0;
      ptr     <= '0;
      oe      <= 1'b0;
      mack_ok <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_e) begin
        st   <= S_DEV;
        bcnt <= '0;
        oe   <= 1'b0;
      end else if (stop_e) begin
        st   <= S_IDLE;
        bcnt <= '0;
        oe   <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_REG, S_WR: begin
            if (scl_rise && bcnt != BCW'(DW)) begin
              sh   <= {sh[DW-2:0], sda_f};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == BCW'(DW)) begin
              bcnt <= '0;
              case (st)
                S_DEV: begin
                  if (sh[DW-1:1] == DEV_ADDR) begin
                    oe    <= 1'b1;
                    st    <= S_SACK;
                    after <= sh[0] ? S_TX : S_REG;
                  end else begin
                    st <= S_HOLD;
                  end
                end
                S_REG: begin
                  ptr   <= sh[PW-1:0];
                  oe    <= 1'b1;
                  st    <= S_SACK;
                  after <= S_WR;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr_next(ptr);
                  oe      <= 1'b1;
                  st      <= S_SACK;
                  after   <= S_WR;
                end
              endcase
            end
          end
          S_SACK: begin
            if (scl_fall) begin
              bcnt <= '0;
              if (after == S_TX) begin
                sh  <= rd_data;
                ptr <= ptr_next(ptr);
                oe  <= ~rd_data[DW-1];
                st  <= S_TX;
              end else begin
                oe <= 1'b0;
                st <= after;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall) begin
              if (bcnt == BCW'(DW)) begin
                oe      <= 1'b0;
                mack_ok <= 1'b0;
                bcnt    <= '0;
                st      <= S_MACK;
              end else begin
                sh <= {sh[DW-2:0], 1'b0};
                oe <= ~sh[DW-2];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              if (!sda_f) mack_ok <= 1'b1;
              else        st      <= S_HOLD;
            end else if (scl_fall && mack_ok) begin
              sh  <= rd_data;
              ptr <= ptr_next(ptr);
              oe  <= ~rd_data[DW-1];
              st  <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = ptr;
  assign sda_oe  = oe;
endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank
  import i2cr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [PW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [PW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] regs_o
);
  logic [DW-1:0] rf [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        rf[g] <= rst_val(g);
      else if (wr_en && wr_addr == PW'(g))
        rf[g] <= wr_data & wr_mask(g);
    end
    assign regs_o[g*DW +: DW] = rf[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == PW'(i)) rd_data = rf[i];
  end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h13,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_o,
  output logic               sda_oe,
  output logic [NREG*DW-1:0] regs_o
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] lines_raw, lines_f;
  logic             scl_rise, scl_fall, start_e, stop_e;
  logic [DW-1:0]    rd_data, wr_data;
  logic [PW-1:0]    rd_addr, wr_addr;
  logic             wr_en;

  assign lines_raw = {scl_i, sda_i};

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    i2cr_sync #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sync (
      .clk(clk), .rst(rst), .line_raw(lines_raw[l]), .line_f(lines_f[l])
    );
  end

  i2cr_cond u_cond (
    .clk(clk), .rst(rst), .scl_f(lines_f[1]), .sda_f(lines_f[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_e(start_e), .stop_e(stop_e)
  );

  i2cr_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_e(start_e), .stop_e(stop_e), .sda_f(lines_f[0]),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  i2cr_regbank u_rb (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_o(regs_o)
  );

  assign sda_o = 1'b0;
endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker
  import i2cr_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               scl_i,
  input logic               sda_oe,
  input logic [NREG*DW-1:0] regs_o,
  input logic               stop_evt,
  input logic               wr_en,
  input logic [PW-1:0]      wr_addr
);
  logic [NREG*DW-1:0] rst_all, zero_bits;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      rst_all[i*DW +: DW]   = rst_val(i);
      zero_bits[i*DW +: DW] = ~wr_mask(i);
    end
  end

  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> regs_o == rst_all);

  a_r5_fixed_zero: assert property (@(posedge clk) disable iff (rst)
    (regs_o & zero_bits) == '0);

  a_r2_drive_on_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  a_r9_release_on_low: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_i);

  a_r11_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);

  a_r10_high_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= PW'(NREG)) |=> $stable(regs_o));
endmodule

bind i2c_regfile_slave i2cr_checker u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .regs_o(regs_o),
  .stop_evt(stop_e), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/sim_i2c_regfile_slave.sv
module sim_i2c_regfile_slave;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        sda_bus;
  logic        sda_o, sda_oe;
  logic [47:0] regs_o;

  always #2 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_regfile_slave u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe(sda_oe), .regs_o(regs_o)
  );

  int ncmp = 0, nbad = 0;
  bit done = 0;

  logic [7:0] exp_val [$];
  string      exp_tag [$];
  logic [7:0] got_byte;
  event       got_ev;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_val.push_back(v);
    exp_tag.push_back(tag);
  endtask

  // monitor: pops one expected item per byte the design returns
  initial forever begin
    @(got_ev);
    if (exp_val.size() == 0) begin
      ncmp++; nbad++;
      $display("FAIL unexpected read byte actual=%0h expected=none", got_byte);
    end else begin
      chk({56'd0, got_byte}, {56'd0, exp_val.pop_front()}, exp_tag.pop_front());
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic bit_io(input logic b, output logic s);
    m_sda = b; wq(); m_scl = 1'b1; wq(); s = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic ack_exp, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    chk({63'd0, ~s}, {63'd0, ack_exp}, tag);
  endtask

  task automatic rd_raw(input logic ack_it, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      v[i] = s;
    end
    bit_io(~ack_it, s);
  endtask

  task automatic rd_byte(input logic ack_it);
    logic [7:0] v;
    rd_raw(ack_it, v);
    got_byte = v;
    -> got_ev;
  endtask

  function automatic logic [47:0] pack6(input logic [7:0] a0, a1, a2, a3, a4, a5);
    return {a5, a4, a3, a2, a1, a0};
  endfunction

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    // R1 reset state
    chk(regs_o, pack6(8'h32, 8'hA1, 8'h3E, 8'h3E, 8'hFF, 8'h09), "R1 reset values");
    chk(sda_oe, 0, "R1 sda released");

    // R3/R4/R5 burst write from pointer E2h (uses 02h), wrapping to 00h
    i2c_start();
    wr_byte(8'h26, 1, "R2 address ack");
    wr_byte(8'hE2, 1, "R3 pointer ack");
    wr_byte(8'h11, 1, "R4 data ack");
    wr_byte(8'h22, 1, "R4 data ack");
    wr_byte(8'h33, 1, "R4 data ack");
    wr_byte(8'h44, 1, "R4 data ack");
    wr_byte(8'hFF, 1, "R4 wrap ack");
    i2c_stop();
    chk(regs_o, pack6(8'hF3, 8'hA1, 8'h11, 8'h22, 8'h33, 8'h04), "R4 R5 R3 burst write wrap");

    // R6 current-address reads
    i2c_start();
    wr_byte(8'h27, 1, "R2 read address ack");
    expect_rd(8'hA1, "R6 current read after write");
    rd_byte(0);
    i2c_stop();
    i2c_start();
    wr_byte(8'h27, 1, "R2 read address ack");
    expect_rd(8'h11, "R6 current read after read");
    rd_byte(0);
    i2c_stop();

    // R7/R8 random read with wrap
    i2c_start();
    wr_byte(8'h26, 1, "R7 address ack");
    wr_byte(8'h04, 1, "R7 pointer ack");
    i2c_start();
    wr_byte(8'h27, 1, "R7 repeated start ack");
    expect_rd(8'h33, "R7 random read first");
    expect_rd(8'h04, "R8 burst read");
    expect_rd(8'hF3, "R8 burst read wrap");
    expect_rd(8'hA1, "R8 burst read after wrap");
    rd_byte(1); rd_byte(1); rd_byte(1); rd_byte(0);
    i2c_stop();

    // R9 master NACK stops transmission
    i2c_start();
    wr_byte(8'h27, 1, "R9 read address ack");
    expect_rd(8'h11, "R9 byte before nack");
    rd_byte(0);
    rd_raw(1, v);
    chk(v, 8'hFF, "R9 no drive after nack");
    i2c_stop();

    // R5 fixed-zero bits
    i2c_start();
    wr_byte(8'h26, 1, "R5 address ack");
    wr_byte(8'h01, 1, "R5 pointer ack");
    wr_byte(8'hFF, 1, "R5 data ack");
    i2c_stop();
    i2c_start();
    wr_byte(8'h26, 1, "R5 address ack");
    wr_byte(8'h05, 1, "R5 pointer ack");
    wr_byte(8'hFF, 1, "R5 data ack");
    i2c_stop();
    chk(regs_o, pack6(8'hF3, 8'hB5, 8'h11, 8'h22, 8'h33, 8'h0F), "R5 masked outputs");
    i2c_start();
    wr_byte(8'h26, 1, "R5 address ack");
    wr_byte(8'h01, 1, "R5 pointer ack");
    i2c_start();
    wr_byte(8'h27, 1, "R5 read address ack");
    expect_rd(8'hB5, "R5 masked readback");
    rd_byte(0);
    i2c_stop();

    // R10 unused pointer range
    i2c_start();
    wr_byte(8'h26, 1, "R10 address ack");
    wr_byte(8'h06, 1, "R10 pointer ack");
    wr_byte(8'h55, 1, "R10 write ack");
    wr_byte(8'h66, 1, "R10 write ack");
    i2c_stop();
    chk(regs_o, pack6(8'hF3, 8'hB5, 8'h11, 8'h22, 8'h33, 8'h0F), "R10 writes discarded");
    i2c_start();
    wr_byte(8'h26, 1, "R10 address ack");
    wr_byte(8'h07, 1, "R10 pointer ack");
    i2c_start();
    wr_byte(8'h27, 1, "R10 read address ack");
    expect_rd(8'h00, "R10 read zero");
    expect_rd(8'h00, "R10 read zero next");
    rd_byte(1); rd_byte(0);
    i2c_stop();

    // R2 foreign address
    i2c_start();
    wr_byte(8'h48, 0, "R2 foreign address nack");
    wr_byte(8'h00, 0, "R2 foreign pointer nack");
    wr_byte(8'h77, 0, "R2 foreign data nack");
    i2c_stop();
    chk(regs_o, pack6(8'hF3, 8'hB5, 8'h11, 8'h22, 8'h33, 8'h0F), "R2 foreign no change");

    // R11 START mid-byte, then STOP mid-byte
    i2c_start();
    wr_byte(8'h26, 1, "R11 address ack");
    wr_byte(8'h02, 1, "R11 pointer ack");
    for (int i = 0; i < 4; i++) bit_io(i[0], v[0]);
    i2c_start();
    wr_byte(8'h26, 1, "R11 restart address ack");
    wr_byte(8'h03, 1, "R11 pointer ack");
    wr_byte(8'h5A, 1, "R11 data ack");
    i2c_stop();
    chk(regs_o, pack6(8'hF3, 8'hB5, 8'h11, 8'h5A, 8'h33, 8'h0F), "R11 abort by start");
    i2c_start();
    wr_byte(8'h26, 1, "R11 address ack");
    wr_byte(8'h02, 1, "R11 pointer ack");
    for (int i = 0; i < 3; i++) bit_io(1'b0, v[0]);
    i2c_stop();
    chk(regs_o, pack6(8'hF3, 8'hB5, 8'h11, 8'h5A, 8'h33, 8'h0F), "R11 abort by stop");
    i2c_start();
    wr_byte(8'h27, 1, "R11 read address ack");
    expect_rd(8'h11, "R11 R6 pointer kept after abort");
    rd_byte(0);
    i2c_stop();

    repeat (20) @(negedge clk);
    chk(exp_val.size(), 0, "scoreboard drained");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      ncmp++; nbad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end
endmodule